// File: doc/BRIEF.md
# Board Reset Sequencer Controller

This controller sits in board glue logic. It combines several reset requests into one timed reset of the processor, and it holds a small bank of writable configuration registers. Three events start a reset sequence: a software start bit in control register 0, a press of the reset button, and a hard-reset request from a debug probe. During a sequence the processor hard reset is held low for a programmed number of cycles. The processor test reset is also pulled low when the sequence came from software or the button, and it is let go a fixed lead time before hard reset. A sequence started by the debug probe leaves test reset alone. A separate external test-reset request is always merged onto the test-reset output.

The register bank has a second job: it decides which reset source clears which storage. Power-on reset clears everything. The general reset input, a held debug request and a watchdog expiry pulse put every configuration register back to its reset value. The auxiliary register is cleared only by power-on reset. All active-low request inputs pass through a two-stage synchronizer. A request counts when its synchronized level falls, so a request that stays low starts only one sequence.

Top module: `board_reset_ctrl`

## Requirements
- R1: After power-on reset, `cpu_hrst_n` and `cpu_trst_n` are high, `seq_done` is low, configuration register 1 reads 64, every other configuration register reads 0 and the auxiliary register reads 0.
- R2: A sequence starts on bit 0 of configuration register 0 being 1, or on a high-to-low change of `btn_rst_n` or `dbg_hrst_n`. The change takes effect after the two-stage synchronizer. A request held low starts exactly one sequence.
- R3: `cpu_hrst_n` stays low for exactly L cycles. L is the value of configuration register 1 taken when the sequence starts, and any value below 16 is treated as 16. `seq_done` is high for one cycle, in the first cycle that `cpu_hrst_n` is high again.
- R4: In a sequence started by the start bit or the button, `cpu_trst_n` is low for the first L-8 cycles of the sequence and then high, which is 8 cycles before hard reset ends.
- R5: A sequence started only by the debug request does not pull `cpu_trst_n` low. A debug request held low after its sequence has ended does not extend `cpu_hrst_n`.
- R6: While the synchronized `ext_trst_n` is low, `cpu_trst_n` is low whatever the sequencer state.
- R7: A start bit, button change or debug change that arrives while a sequence is running is ignored. A 1 written to the start bit during a sequence is dropped and reads back 0.
- R8: The start bit returns to 0 in the same cycle its sequence begins.
- R9: A `wdog_exp` pulse, a low synchronized `gen_rst_n` or a low synchronized `dbg_hrst_n` returns all configuration registers to their reset values. This clear takes priority over a write in the same cycle.
- R10: The auxiliary register keeps its value through watchdog, debug and general resets. Only power-on reset clears it.
- R11: A write to address i below 4 updates configuration register i, and a write to address 4 updates the auxiliary register. Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| gen_rst_n | input | 1 | General reset request, active low, clears configuration registers |
| btn_rst_n | input | 1 | Reset button, active low, starts a sequence that includes test reset |
| dbg_hrst_n | input | 1 | Debug probe hard-reset request, active low |
| ext_trst_n | input | 1 | External test-reset request, active low |
| wdog_exp | input | 1 | Watchdog expiry pulse, synchronous, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| cpu_hrst_n | output | 1 | Processor hard reset, active low |
| cpu_trst_n | output | 1 | Processor test reset, active low |
| seq_done | output | 1 | One-cycle pulse when hard reset is released |
| cfg_flat | output | 32 | Configuration registers; register i at bits [8i+7:8i] |
| aux_reg | output | 8 | Auxiliary register |

## Verification
Sequences are started in turn by the start bit, a button press held far longer than the sequence, and a held debug request. Together they separate the trigger sources that include test reset from the one that does not, and they show whether a held level restarts the sequencer. The hold length is tried at the default, at a small programmed value and at a value below the floor. These runs expose off-by-one counting and a missing clamp. Extra button presses and start-bit writes arrive during a running sequence and must be absorbed. Watchdog, general and debug resets are applied around register writes, including one in the same cycle as a write. These show whether each register has the right set of clearing sources and whether the clear wins over the write.

// File: rtl/brc_pkg.sv
package brc_pkg;

    // Start requests seen by the sequencer in one cycle
    typedef struct packed {
        logic go;
        logic btn;
        logic dbg;
    } trig_t;

    // Previous synchronized levels for fall detection
    typedef struct packed {
        logic btn;
        logic dbg;
    } edge_t;

endpackage

// File: rtl/brc_sync.sv
module brc_sync #(
    parameter int             W       = 4,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = async_i;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {RST_VAL, RST_VAL};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q.s2;

endmodule

// File: rtl/brc_seq.sv
module brc_seq import brc_pkg::*; #(
    parameter int CW      = 8,
    parameter int LEAD    = 8,
    parameter int MIN_LEN = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  trig_t         trig_i,
    input  logic [CW-1:0] len_cfg_i,
    output logic          start_o,
    output logic          busy_o,
    output logic          hrst_n_o,
    output logic          seq_trst_o,
    output logic          done_o
);

    localparam logic [CW-1:0] MIN_L  = CW'(MIN_LEN);
    localparam logic [CW-1:0] LEAD_L = CW'(LEAD);

    typedef struct packed {
        logic          busy;
        logic          tmode;
        logic          done;
        logic [CW-1:0] cnt;
        logic [CW-1:0] len;
    } seq_t;

    seq_t          seq_d, seq_q;
    logic [CW-1:0] len_eff;

    always_comb begin
        len_eff = (len_cfg_i < MIN_L) ? MIN_L : len_cfg_i;
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        start_o    = 1'b0;
        if (!seq_q.busy) begin
            if (trig_i.go || trig_i.btn || trig_i.dbg) begin
                start_o     = 1'b1;
                seq_d.busy  = 1'b1;
                seq_d.tmode = trig_i.go || trig_i.btn;
                seq_d.cnt   = '0;
                seq_d.len   = len_eff;
            end
        end else if (seq_q.cnt == seq_q.len - CW'(1)) begin
            seq_d.busy = 1'b0;
            seq_d.done = 1'b1;
        end else begin
            seq_d.cnt = seq_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o     = seq_q.busy;
    assign hrst_n_o   = ~seq_q.busy;
    assign done_o     = seq_q.done;
    assign seq_trst_o = seq_q.busy && seq_q.tmode && (seq_q.cnt < seq_q.len - LEAD_L);

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3
    release_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hrst_n_o) |-> done_o);

    // R4
    trst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && (trig_i.go || trig_i.btn)) |=> (!hrst_n_o && seq_trst_o));

    // R4
    trst_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hrst_n_o) |-> !$past(seq_trst_o));

    // R5
    dbg_no_trst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && !trig_i.go && !trig_i.btn) |=> !seq_trst_o);

endmodule

// File: rtl/brc_regs.sv
module brc_regs #(
    parameter int NCFG    = 4,
    parameter int DW      = 8,
    parameter int AW      = 3,
    parameter int LEN_IDX = 1,
    parameter int LEN_RST = 64
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               clr_i,
    input  logic               go_clr_i,
    input  logic               wr_en_i,
    input  logic [AW-1:0]      wr_addr_i,
    input  logic [DW-1:0]      wr_data_i,
    output logic [NCFG*DW-1:0] cfg_o,
    output logic [DW-1:0]      aux_o,
    output logic               go_o,
    output logic [DW-1:0]      len_o
);

    function automatic logic [NCFG-1:0][DW-1:0] rst_vals();
        logic [NCFG-1:0][DW-1:0] r;
        r          = '0;
        r[LEN_IDX] = DW'(LEN_RST);
        return r;
    endfunction

    localparam logic [NCFG-1:0][DW-1:0] CFG_RST = rst_vals();

    typedef struct packed {
        logic [NCFG-1:0][DW-1:0] cfg;
        logic [DW-1:0]           aux;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NCFG; i++) begin
            if (wr_en_i && wr_addr_i == AW'(i)) begin
                bank_d.cfg[i] = wr_data_i;
            end
        end
        if (wr_en_i && wr_addr_i == AW'(NCFG)) begin
            bank_d.aux = wr_data_i;
        end
        if (clr_i) begin
            bank_d.cfg = CFG_RST;
        end
        if (go_clr_i) begin
            bank_d.cfg[0][0] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            bank_q <= '{cfg: CFG_RST, aux: '0};
        end else begin
            bank_q <= bank_d;
        end
    end

    assign cfg_o = bank_q.cfg;
    assign aux_o = bank_q.aux;
    assign go_o  = bank_q.cfg[0][0];
    assign len_o = bank_q.cfg[LEN_IDX];

    // R10
    aux_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !(wr_en_i && wr_addr_i == AW'(NCFG)) |=> $stable(aux_o));

    // R9
    clr_apply_chk: assert property (@(posedge clk) disable iff (!por_n)
        clr_i |=> (cfg_o == CFG_RST));

    // R8
    go_drop_chk: assert property (@(posedge clk) disable iff (!por_n)
        go_clr_i |=> !go_o);

endmodule

// File: rtl/board_reset_ctrl.sv
module board_reset_ctrl import brc_pkg::*; #(
    parameter  int NCFG      = 4,
    parameter  int DW        = 8,
    parameter  int HOLD_DEF  = 64,
    parameter  int TRST_LEAD = 8,
    parameter  int MIN_HOLD  = 16,
    localparam int AW        = $clog2(NCFG + 1)
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               gen_rst_n,
    input  logic               btn_rst_n,
    input  logic               dbg_hrst_n,
    input  logic               ext_trst_n,
    input  logic               wdog_exp,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    output logic               cpu_hrst_n,
    output logic               cpu_trst_n,
    output logic               seq_done,
    output logic [NCFG*DW-1:0] cfg_flat,
    output logic [DW-1:0]      aux_reg
);

    localparam int NSYNC = 4;

    logic [NSYNC-1:0] raw_n, sync_n;
    logic             btn_s, dbg_s, gen_s, ext_s;
    edge_t            edge_d, edge_q;
    trig_t            trig;
    logic             go_bit, clr_cfg, go_clr;
    logic             seq_start, seq_busy, seq_trst;
    logic [DW-1:0]    len_cfg;

    assign raw_n = {ext_trst_n, gen_rst_n, dbg_hrst_n, btn_rst_n};

    brc_sync #(.W(NSYNC), .RST_VAL({NSYNC{1'b1}})) u_sync (
        .clk     (clk),
        .rst_n   (por_n),
        .async_i (raw_n),
        .sync_o  (sync_n)
    );

    assign btn_s = sync_n[0];
    assign dbg_s = sync_n[1];
    assign gen_s = sync_n[2];
    assign ext_s = sync_n[3];

    always_comb begin
        edge_d     = edge_q;
        edge_d.btn = btn_s;
        edge_d.dbg = dbg_s;
        trig.go    = go_bit;
        trig.btn   = edge_q.btn & ~btn_s;
        trig.dbg   = edge_q.dbg & ~dbg_s;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            edge_q <= '1;
        end else begin
            edge_q <= edge_d;
        end
    end

    assign clr_cfg = ~gen_s | ~dbg_s | wdog_exp;
    assign go_clr  = seq_busy | seq_start;

    brc_seq #(.CW(DW), .LEAD(TRST_LEAD), .MIN_LEN(MIN_HOLD)) u_seq (
        .clk        (clk),
        .rst_n      (por_n),
        .trig_i     (trig),
        .len_cfg_i  (len_cfg),
        .start_o    (seq_start),
        .busy_o     (seq_busy),
        .hrst_n_o   (cpu_hrst_n),
        .seq_trst_o (seq_trst),
        .done_o     (seq_done)
    );

    brc_regs #(.NCFG(NCFG), .DW(DW), .AW(AW), .LEN_IDX(1), .LEN_RST(HOLD_DEF)) u_regs (
        .clk       (clk),
        .por_n     (por_n),
        .clr_i     (clr_cfg),
        .go_clr_i  (go_clr),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .cfg_o     (cfg_flat),
        .aux_o     (aux_reg),
        .go_o      (go_bit),
        .len_o     (len_cfg)
    );

    assign cpu_trst_n = ~(seq_trst | ~ext_s);

endmodule

// File: tb/test_board_reset_ctrl.sv
module test_board_reset_ctrl;

    localparam int NCFG = 4;
    localparam int DW   = 8;
    localparam int AW   = 3;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          gen_rst_n = 1'b1, btn_rst_n = 1'b1, dbg_hrst_n = 1'b1, ext_trst_n = 1'b1;
    logic          wdog_exp = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          cpu_hrst_n, cpu_trst_n, seq_done;
    logic [NCFG*DW-1:0] cfg_flat;
    logic [DW-1:0] aux_reg;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    board_reset_ctrl i_board_reset_ctrl (
        .clk(clk), .por_n(por_n), .gen_rst_n(gen_rst_n), .btn_rst_n(btn_rst_n),
        .dbg_hrst_n(dbg_hrst_n), .ext_trst_n(ext_trst_n), .wdog_exp(wdog_exp),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cpu_hrst_n(cpu_hrst_n), .cpu_trst_n(cpu_trst_n), .seq_done(seq_done),
        .cfg_flat(cfg_flat), .aux_reg(aux_reg)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [DW-1:0] m_cfg [NCFG];
    logic [DW-1:0] m_aux;
    int            rem;
    bit            m_tm, m_done;
    bit            bh[3], dh[3], gh[3], eh[3];   // input samples, [0] newest

    function automatic logic [NCFG*DW-1:0] m_flat();
        logic [NCFG*DW-1:0] f;
        for (int i = 0; i < NCFG; i++) f[i*DW +: DW] = m_cfg[i];
        return f;
    endfunction

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            for (int i = 0; i < NCFG; i++) m_cfg[i] = '0;
            m_cfg[1] = 8'd64;
            m_aux = '0; rem = 0; m_tm = 0; m_done = 0;
            for (int i = 0; i < 3; i++) begin bh[i] = 1; dh[i] = 1; gh[i] = 1; eh[i] = 1; end
        end else begin
            bit go_t, btn_f, dbg_f, was_busy, start, clr;
            int snap;
            go_t     = m_cfg[0][0];
            btn_f    = bh[2] && !bh[1];
            dbg_f    = dh[2] && !dh[1];
            was_busy = rem > 0;
            start    = !was_busy && (go_t || btn_f || dbg_f);
            clr      = !gh[1] || !dh[1] || wdog_exp;
            snap     = int'(m_cfg[1]);
            if (wr_en) begin
                if (int'(wr_addr) < NCFG) m_cfg[int'(wr_addr)] = wr_data;
                else if (int'(wr_addr) == NCFG) m_aux = wr_data;
            end
            if (clr) begin
                for (int i = 0; i < NCFG; i++) m_cfg[i] = '0;
                m_cfg[1] = 8'd64;
            end
            if (was_busy || start) m_cfg[0][0] = 1'b0;
            m_done = 0;
            if (start) begin
                rem  = (snap < 16) ? 16 : snap;
                m_tm = go_t || btn_f;
            end else if (was_busy) begin
                rem--;
                if (rem == 0) m_done = 1;
            end
            bh[2] = bh[1]; bh[1] = bh[0]; bh[0] = btn_rst_n;
            dh[2] = dh[1]; dh[1] = dh[0]; dh[0] = dbg_hrst_n;
            gh[2] = gh[1]; gh[1] = gh[0]; gh[0] = gen_rst_n;
            eh[2] = eh[1]; eh[1] = eh[0]; eh[0] = ext_trst_n;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (por_n) begin
            chk("R3", "cpu_hrst_n", cpu_hrst_n, !(rem > 0));
            chk("R4", "cpu_trst_n", cpu_trst_n, !((m_tm && rem > 8) || !eh[1]));
            chk("R3", "seq_done", seq_done, m_done);
            chk("R9", "cfg_flat", cfg_flat, m_flat());
            chk("R10", "aux_reg", aux_reg, m_aux);
        end
    end

    // window counters, sampled at the edge before the design updates
    int c_hrst, c_trst, c_done;
    always @(posedge clk) begin
        if (!cpu_hrst_n) c_hrst++;
        if (!cpu_trst_n) c_trst++;
        if (seq_done)    c_done++;
    end

    task automatic clr_cnt(); c_hrst = 0; c_trst = 0; c_done = 0; endtask
    task automatic tick(input int n); repeat (n) @(negedge clk); endtask
    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
        tick(1);
        wr_en = 1'b0;
    endtask
    task automatic press(input int n);
        btn_rst_n = 1'b0; tick(n); btn_rst_n = 1'b1;
    endtask
    function automatic int cfg_at(input int i);
        return int'(cfg_flat[i*DW +: DW]);
    endfunction

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog expired: actual 0 expected 1");
        report();
    end

    initial begin
        tick(5);
        por_n = 1'b1;
        tick(2);
        // R1 reset state
        chk("R1", "hrst after por", cpu_hrst_n, 1);
        chk("R1", "trst after por", cpu_trst_n, 1);
        chk("R1", "done after por", seq_done, 0);
        chk("R1", "len reg after por", cfg_at(1), 64);
        chk("R1", "reg0 after por", cfg_at(0), 0);
        chk("R1", "aux after por", aux_reg, 0);

        // R2 held button starts one sequence, R3/R4 default length
        clr_cnt(); press(100); tick(20);
        chk("R2", "button held: done pulses", c_done, 1);
        chk("R3", "button: hrst cycles", c_hrst, 64);
        chk("R4", "button: trst cycles", c_trst, 56);

        // R8 start bit self clears, R2 start bit trigger
        clr_cnt(); wr(0, 1); tick(1);
        chk("R8", "start bit after start", cfg_at(0) & 1, 0);
        tick(80);
        chk("R2", "start bit: done pulses", c_done, 1);
        chk("R4", "start bit: trst cycles", c_trst, 56);

        // R7 triggers during a sequence ignored
        clr_cnt(); press(10); tick(10); press(5); wr(0, 1);
        chk("R7", "start bit written while busy", cfg_at(0) & 1, 0);
        tick(80);
        chk("R7", "busy triggers: done pulses", c_done, 1);
        chk("R7", "busy triggers: hrst cycles", c_hrst, 64);

        // R3 programmed and clamped lengths
        wr(1, 20); clr_cnt(); press(3); tick(40);
        chk("R3", "len 20: hrst cycles", c_hrst, 20);
        chk("R4", "len 20: trst cycles", c_trst, 12);
        wr(1, 5); clr_cnt(); press(3); tick(40);
        chk("R3", "len 5 clamped: hrst cycles", c_hrst, 16);
        chk("R4", "len 5 clamped: trst cycles", c_trst, 8);

        // R5 debug sequence: no trst, held request does not extend
        wr(1, 30); wr(4, 8'h3C);
        clr_cnt(); dbg_hrst_n = 1'b0; tick(150); dbg_hrst_n = 1'b1; tick(5);
        chk("R5", "debug: hrst cycles", c_hrst, 30);
        chk("R5", "debug: trst cycles", c_trst, 0);
        chk("R9", "debug clears len reg", cfg_at(1), 64);
        chk("R10", "aux after debug", aux_reg, 8'h3C);

        // R6 external test reset while idle
        clr_cnt(); ext_trst_n = 1'b0; tick(10); ext_trst_n = 1'b1; tick(5);
        chk("R6", "ext trst cycles", c_trst, 10);
        chk("R6", "ext trst: no hard reset", c_hrst, 0);

        // R9 watchdog clear, priority over a same-cycle write
        wr(2, 8'hA5); wr(1, 40);
        chk("R11", "reg2 write", cfg_at(2), 8'hA5);
        wdog_exp = 1'b1; wr(3, 8'h77); wdog_exp = 1'b0; tick(1);
        chk("R9", "wdog clears reg2", cfg_at(2), 0);
        chk("R9", "wdog beats write reg3", cfg_at(3), 0);
        chk("R9", "wdog restores len", cfg_at(1), 64);
        chk("R10", "aux after wdog", aux_reg, 8'h3C);
        wr(2, 8'h11);
        gen_rst_n = 1'b0; tick(4); gen_rst_n = 1'b1; tick(4);
        chk("R9", "gen clears reg2", cfg_at(2), 0);
        chk("R10", "aux after gen", aux_reg, 8'h3C);

        // R11 out-of-range address ignored
        wr(2, 8'h22); wr(7, 8'hFF); tick(1);
        chk("R11", "addr 7: reg2", cfg_at(2), 8'h22);
        chk("R11", "addr 7: reg3", cfg_at(3), 0);
        chk("R11", "addr 7: aux", aux_reg, 8'h3C);

        // R10 power-on reset clears aux
        por_n = 1'b0; tick(3);
        chk("R10", "aux after por", aux_reg, 0);
        por_n = 1'b1; tick(3);
        report();
    end

endmodule